// File: doc/BRIEF.md
# Card-Resident DMA Responder with FIFO Interrupts

This block sits between a host register port and a serial communications controller that moves its data by DMA. It holds a transmit FIFO and a receive FIFO. When the controller raises a transmit request, the block hands it the oldest byte of the transmit FIFO in the same cycle. When the controller raises a receive request, the block stores the presented byte in the receive FIFO. The host only fills and drains the FIFOs through a data register, so it is never in the per-byte path.

Transmit acknowledges stop as soon as the transmit FIFO runs dry. The controller then sees no acknowledge and ends its frame. Three FIFO events latch pending bits: the transmit level falling below half, the transmit FIFO reaching empty, and the receive level rising above half. Each event fires once per crossing. The controller's own interrupt line is passed through as a fourth pending source. One IRQ output combines the pending sources under a mask, a master enable and an in-service lock.

Top module: `dma_fifo_irq`

## Requirements
- R1: `txAck` is 1 only in a cycle where `txReq` is 1, transmit DMA enable (control bit 2) is 1 and the transmit FIFO holds at least one byte. When the FIFO is empty, further requests get no acknowledge. Each acknowledge presents the head byte on `txData` and removes it.
- R2: `rxAck` is 1 only in a cycle where `rxReq` is 1, receive DMA enable (control bit 3) is 1 and the receive FIFO is not full. Each acknowledge stores `rxData`.
- R3: Pending bit 2 is set when a DMA removal takes the transmit level from DEPTH/2 to DEPTH/2-1. It is cleared by an accepted host write to the data register (address 4), or by writing mask bit 2 to 1 and then back to 0.
- R4: Pending bit 3 is set when the transmit FIFO goes from one byte to empty. It is cleared only by writing mask bit 3 to 1 and then back to 0. A host data write leaves it set.
- R5: Pending bit 1 is set when a DMA store takes the receive level from DEPTH/2 to DEPTH/2+1. It is cleared by an accepted host read of the data register, or by writing mask bit 1 to 1 and then back to 0.
- R6: Pending bit 0 follows `ctlIrqIn` directly and is masked by mask bit 0.
- R7: A masked source keeps its pending bit latched (readable at address 2) but does not drive `irq`.
- R8: `irq` = control bit 0 (master enable) AND NOT control bit 1 (in-service) AND (any pending bit whose mask bit is 0). Clearing the in-service bit re-asserts `irq` at once if a source is still pending.
- R9: The status flags are active low. Empty is low when the level is 0, half is low when the level is at least DEPTH/2, and full is low when the level is DEPTH. Address 3 reads them as {rxFullN, rxHalfN, rxEmptyN, txFullN, txHalfN, txEmptyN} in bits 5..0.
- R10: When a host access to the data register meets a DMA acknowledge in the same cycle, the DMA is served and `hostReady` is 0. The host access completes on a later cycle without a DMA.
- R11: Both FIFOs keep first-in first-out order. Transmit bytes leave in the order the host wrote them, and receive bytes are read back in the order the DMA stored them.
- R12: After reset, the control, mask and latched pending registers are 0, `irq` is 0, and both FIFOs are empty (status reads 0x36).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 3 | 0 control, 1 mask, 2 pending, 3 status, 4 FIFO data |
| hostWdata | input | WIDTH | Host write data |
| hostRdata | output | WIDTH | Host read data, valid while hostRd and hostReady |
| hostReady | output | 1 | Host access accepted this cycle |
| txReq | input | 1 | Controller transmit DMA request |
| txAck | output | 1 | Transmit acknowledge, byte on txData taken |
| txData | output | WIDTH | Head byte of the transmit FIFO |
| rxReq | input | 1 | Controller receive DMA request |
| rxAck | output | 1 | Receive acknowledge, rxData stored |
| rxData | input | WIDTH | Byte offered by the controller |
| ctlIrqIn | input | 1 | Controller interrupt line |
| irq | output | 1 | Host interrupt request |
| txEmptyN | output | 1 | Transmit FIFO empty, active low |
| txHalfN | output | 1 | Transmit FIFO at least half, active low |
| txFullN | output | 1 | Transmit FIFO full, active low |
| rxEmptyN | output | 1 | Receive FIFO empty, active low |
| rxHalfN | output | 1 | Receive FIFO at least half, active low |
| rxFullN | output | 1 | Receive FIFO full, active low |

## Verification
The bench builds the block with DEPTH = 16 and WIDTH = 8. With this depth, the half crossings (8 to 7 on transmit, 8 to 9 on receive), the empty stop and the full refusal all come within a few dozen transfers, so each threshold can be hit and cleared more than once. The shallow FIFO also lets the bench run both clear paths for each latched source and still check byte order across a full wrap of the pointers.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_MASK = 3'd1;
  localparam logic [2:0] ADDR_PEND = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_DATA = 3'd4;

  localparam int CR_MASTER = 0;
  localparam int CR_INSVC  = 1;
  localparam int CR_TXEN   = 2;
  localparam int CR_RXEN   = 3;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     push,
  input  logic                     pop,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  assign rdata = mem[rdPtr];
  assign count = level;

  // R11: storage never written past full or read past empty
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (level != CW'(DEPTH)));
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (level != '0));
endmodule

// File: rtl/dma_dp.sv
module dma_dp
  import dma_resp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobe_t            stb,
  input  logic [WIDTH-1:0]       hostWdata,
  input  logic [WIDTH-1:0]       rxDmaData,
  output logic [WIDTH-1:0]       txData,
  output logic [WIDTH-1:0]       rxRdata,
  output logic [$clog2(DEPTH):0] txCount,
  output logic [$clog2(DEPTH):0] rxCount,
  output logic [5:0]             flagsN
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic             pushV [2];
  logic             popV  [2];
  logic [WIDTH-1:0] dinV  [2];
  logic [WIDTH-1:0] doutV [2];
  logic [CW-1:0]    cntV  [2];

  assign pushV[0] = stb.txPush;
  assign popV[0]  = stb.txPop;
  assign dinV[0]  = hostWdata;
  assign pushV[1] = stb.rxPush;
  assign popV[1]  = stb.rxPop;
  assign dinV[1]  = rxDmaData;

  // index 0 = transmit, index 1 = receive
  for (genvar i = 0; i < 2; i++) begin : g_fifo
    dma_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (pushV[i]),
      .pop   (popV[i]),
      .wdata (dinV[i]),
      .rdata (doutV[i]),
      .count (cntV[i])
    );
    // R9: active-low flags
    assign flagsN[3*i+0] = (cntV[i] != '0);
    assign flagsN[3*i+1] = (cntV[i] < HALF);
    assign flagsN[3*i+2] = (cntV[i] != FULL);
  end

  assign txData  = doutV[0];
  assign rxRdata = doutV[1];
  assign txCount = cntV[0];
  assign rxCount = cntV[1];
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_resp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWr,
  input  logic                   hostRd,
  input  logic [2:0]             hostAddr,
  input  logic [WIDTH-1:0]       hostWdata,
  output logic [WIDTH-1:0]       hostRdata,
  output logic                   hostReady,
  input  logic                   txReq,
  output logic                   txAck,
  input  logic                   rxReq,
  output logic                   rxAck,
  input  logic                   ctlIrqIn,
  output logic                   irq,
  input  logic [$clog2(DEPTH):0] txCount,
  input  logic [$clog2(DEPTH):0] rxCount,
  input  logic [5:0]             flagsN,
  input  logic [WIDTH-1:0]       rxRdata,
  output fifoStrobe_t            stb
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [WIDTH-1:0] ctrlReg, maskReg;
  logic [3:1]       pendReg;
  logic [3:0]       pendAll, maskFall;
  logic             hostData, dmaBusy, hostWrOk, hostRdOk;
  logic             txHalfEvt, txEmptyEvt, rxHalfEvt;

  // DMA side: acknowledge in the request cycle
  assign txAck = txReq && ctrlReg[CR_TXEN] && (txCount != '0);
  assign rxAck = rxReq && ctrlReg[CR_RXEN] && (rxCount != FULL);

  // host side: stalled when it would touch FIFO data alongside a DMA transfer
  assign hostData  = (hostAddr == ADDR_DATA);
  assign dmaBusy   = txAck || rxAck;
  assign hostReady = !((hostWr || hostRd) && hostData && dmaBusy);
  assign hostWrOk  = hostWr && hostReady;
  assign hostRdOk  = hostRd && hostReady;

  assign stb.txPush = hostWrOk && hostData && (txCount != FULL);
  assign stb.txPop  = txAck;
  assign stb.rxPush = rxAck;
  assign stb.rxPop  = hostRdOk && hostData && (rxCount != '0);

  // threshold crossings
  assign txHalfEvt  = stb.txPop && !stb.txPush && (txCount == HALF);
  assign txEmptyEvt = stb.txPop && (txCount == ONE);
  assign rxHalfEvt  = stb.rxPush && !stb.rxPop && (rxCount == HALF);

  // a mask bit going 1 -> 0 completes the 0-1-0 clear sequence
  assign maskFall = (hostWrOk && hostAddr == ADDR_MASK) ?
                    (maskReg[3:0] & ~hostWdata[3:0]) : 4'b0000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskReg <= '0;
      pendReg <= '0;
    end else begin
      if (hostWrOk && hostAddr == ADDR_CTRL) ctrlReg <= hostWdata;
      if (hostWrOk && hostAddr == ADDR_MASK) maskReg <= hostWdata;
      pendReg[1] <= rxHalfEvt  | (pendReg[1] & ~((hostRdOk && hostData) | maskFall[1]));
      pendReg[2] <= txHalfEvt  | (pendReg[2] & ~((hostWrOk && hostData) | maskFall[2]));
      pendReg[3] <= txEmptyEvt | (pendReg[3] & ~maskFall[3]);
    end
  end

  assign pendAll = {pendReg, ctlIrqIn};
  assign irq = ctrlReg[CR_MASTER] && !ctrlReg[CR_INSVC] && (|(pendAll & ~maskReg[3:0]));

  always_comb begin
    case (hostAddr)
      ADDR_CTRL: hostRdata = ctrlReg;
      ADDR_MASK: hostRdata = maskReg;
      ADDR_PEND: hostRdata = WIDTH'(pendAll);
      ADDR_STAT: hostRdata = WIDTH'(flagsN);
      ADDR_DATA: hostRdata = rxRdata;
      default:   hostRdata = '0;
    endcase
  end

  // R1: no transmit acknowledge while the datapath reports empty
  p_txack_nonempty_r1: assert property (@(posedge clk) disable iff (!rstN)
    txAck |-> flagsN[0]);
  // R2: no receive acknowledge while the datapath reports full
  p_rxack_notfull_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxAck |-> flagsN[5]);
  // R3: falling through half latches pending bit 2
  p_txhalf_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txAck && txCount == HALF) |=> pendAll[2]);
  // R4: draining to empty latches pending bit 3
  p_txempty_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txAck && txCount == ONE) |=> pendAll[3]);
  // R5: rising past half latches pending bit 1
  p_rxhalf_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxAck && !stb.rxPop && rxCount == HALF) |=> pendAll[1]);
  // R10: a host stall only happens alongside a DMA transfer
  p_stall_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hostReady |-> (txAck || rxAck));
endmodule

// File: rtl/dma_fifo_irq.sv
module dma_fifo_irq
  import dma_resp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [2:0]       hostAddr,
  input  logic [WIDTH-1:0] hostWdata,
  output logic [WIDTH-1:0] hostRdata,
  output logic             hostReady,
  input  logic             txReq,
  output logic             txAck,
  output logic [WIDTH-1:0] txData,
  input  logic             rxReq,
  output logic             rxAck,
  input  logic [WIDTH-1:0] rxData,
  input  logic             ctlIrqIn,
  output logic             irq,
  output logic             txEmptyN,
  output logic             txHalfN,
  output logic             txFullN,
  output logic             rxEmptyN,
  output logic             rxHalfN,
  output logic             rxFullN
);
  localparam int CW = $clog2(DEPTH) + 1;

  fifoStrobe_t      stb;
  logic [CW-1:0]    txCount, rxCount;
  logic [5:0]       flagsN;
  logic [WIDTH-1:0] rxRdata;

  dma_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .hostReady (hostReady),
    .txReq     (txReq),
    .txAck     (txAck),
    .rxReq     (rxReq),
    .rxAck     (rxAck),
    .ctlIrqIn  (ctlIrqIn),
    .irq       (irq),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .flagsN    (flagsN),
    .rxRdata   (rxRdata),
    .stb       (stb)
  );

  dma_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .rxDmaData (rxData),
    .txData    (txData),
    .rxRdata   (rxRdata),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .flagsN    (flagsN)
  );

  assign txEmptyN = flagsN[0];
  assign txHalfN  = flagsN[1];
  assign txFullN  = flagsN[2];
  assign rxEmptyN = flagsN[3];
  assign rxHalfN  = flagsN[4];
  assign rxFullN  = flagsN[5];
endmodule

// File: tb/sim_dma_fifo_irq.sv
module sim_dma_fifo_irq;
  import dma_resp_pkg::*;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0]       hostAddr = '0;
  logic [WIDTH-1:0] hostWdata = '0;
  logic [WIDTH-1:0] hostRdata;
  logic             hostReady;
  logic             txReq = 1'b0, txAck;
  logic [WIDTH-1:0] txData;
  logic             rxReq = 1'b0, rxAck;
  logic [WIDTH-1:0] rxData = '0;
  logic             ctlIrqIn = 1'b0, irq;
  logic             txEmptyN, txHalfN, txFullN, rxEmptyN, rxHalfN, rxFullN;

  int nChecks = 0;
  int nFail   = 0;
  logic [WIDTH-1:0] txQ[$];
  logic [WIDTH-1:0] rxQ[$];

  always #2 clk = ~clk;  // 250 MHz

  dma_fifo_irq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostReady(hostReady),
    .txReq(txReq), .txAck(txAck), .txData(txData), .rxReq(rxReq), .rxAck(rxAck),
    .rxData(rxData), .ctlIrqIn(ctlIrqIn), .irq(irq),
    .txEmptyN(txEmptyN), .txHalfN(txHalfN), .txFullN(txFullN),
    .rxEmptyN(rxEmptyN), .rxHalfN(rxHalfN), .rxFullN(rxFullN));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    #1;
    while (!hostReady) begin @(negedge clk); #1; end
    if (a == ADDR_DATA) txQ.push_back(d);
    @(posedge clk); #1;
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [WIDTH-1:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    #1;
    while (!hostReady) begin @(negedge clk); #1; end
    d = hostRdata;
    @(posedge clk); #1;
    hostRd = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [2:0] a, input logic [WIDTH-1:0] e);
    logic [WIDTH-1:0] v;
    hostRead(a, v);
    chk(tag, v, e);
  endtask

  task automatic txDma(input string tag, input logic expAck);
    @(negedge clk);
    txReq = 1'b1;
    #1;
    chk(tag, txAck, expAck);
    @(posedge clk); #1;
    txReq = 1'b0;
  endtask

  task automatic rxDma(input string tag, input logic [WIDTH-1:0] d, input logic expAck);
    @(negedge clk);
    rxReq = 1'b1; rxData = d;
    #1;
    chk(tag, rxAck, expAck);
    if (expAck) rxQ.push_back(d);
    @(posedge clk); #1;
    rxReq = 1'b0;
  endtask

  task automatic readRxData(input string tag);
    logic [WIDTH-1:0] v;
    hostRead(ADDR_DATA, v);
    if (rxQ.size() == 0) chk({tag, " queue empty"}, 1, 0);
    else chk(tag, v, rxQ.pop_front());
  endtask

  // monitor: pops expected transmit bytes as the design hands them out (R11)
  initial begin
    forever begin
      @(negedge clk); #1;
      if (txAck) begin
        if (txQ.size() == 0) chk("R11 tx byte with nothing expected", 1, 0);
        else chk("R11 tx order", txData, txQ.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    chk("R12 irq", irq, 0);
    chk("R12 flag ports", {rxFullN, rxHalfN, rxEmptyN, txFullN, txHalfN, txEmptyN}, 6'h36);
    expectReg("R12 ctrl", ADDR_CTRL, 8'h00);
    expectReg("R12 mask", ADDR_MASK, 8'h00);
    expectReg("R12 pending", ADDR_PEND, 8'h00);
    expectReg("R12 R9 status", ADDR_STAT, 8'h36);

    // R1 gating
    txDma("R1 disabled and empty", 0);
    hostWrite(ADDR_CTRL, 8'h04);
    txDma("R1 enabled but empty", 0);
    hostWrite(ADDR_CTRL, 8'h00);
    for (int i = 0; i < 9; i++) hostWrite(ADDR_DATA, 8'hA0 + 8'(i));
    expectReg("R9 status tx 9", ADDR_STAT, 8'h35);
    chk("R9 txHalfN port", txHalfN, 0);
    txDma("R1 disabled nonempty", 0);
    hostWrite(ADDR_CTRL, 8'h04);
    txDma("R1 ack 1", 1);
    expectReg("R3 no half event at 9->8", ADDR_PEND, 8'h00);
    txDma("R1 ack 2", 1);
    expectReg("R3 half crossing", ADDR_PEND, 8'h04);
    for (int i = 0; i < 7; i++) txDma("R1 drain", 1);
    expectReg("R4 empty latched", ADDR_PEND, 8'h0C);
    txDma("R1 stop at empty", 0);
    expectReg("R9 status empty", ADDR_STAT, 8'h36);

    // R8 irq gating
    chk("R8 master off", irq, 0);
    hostWrite(ADDR_CTRL, 8'h05);
    chk("R8 master on", irq, 1);
    hostWrite(ADDR_CTRL, 8'h07);
    chk("R8 in-service lock", irq, 0);
    hostWrite(ADDR_CTRL, 8'h05);
    chk("R8 in-service release", irq, 1);

    // R3 clear by write, R4 survives write
    hostWrite(ADDR_DATA, 8'h55);
    expectReg("R3 R4 write clears half only", ADDR_PEND, 8'h08);
    txDma("R1 single", 1);
    hostWrite(ADDR_MASK, 8'h08);
    chk("R7 masked no irq", irq, 0);
    expectReg("R7 still latched", ADDR_PEND, 8'h08);
    hostWrite(ADDR_MASK, 8'h00);
    expectReg("R4 toggle clear", ADDR_PEND, 8'h00);
    chk("R8 nothing pending", irq, 0);

    // R3 clear by toggle
    hostWrite(ADDR_CTRL, 8'h01);
    for (int i = 0; i < 9; i++) hostWrite(ADDR_DATA, 8'h10 + 8'(i));
    hostWrite(ADDR_CTRL, 8'h05);
    txDma("R1 a", 1);
    txDma("R1 b", 1);
    expectReg("R3 half again", ADDR_PEND, 8'h04);
    chk("R8 half irq", irq, 1);
    hostWrite(ADDR_MASK, 8'h04);
    chk("R7 half masked", irq, 0);
    hostWrite(ADDR_MASK, 8'h00);
    expectReg("R3 toggle clear", ADDR_PEND, 8'h00);
    for (int i = 0; i < 7; i++) txDma("R1 drain2", 1);
    hostWrite(ADDR_MASK, 8'h08);
    hostWrite(ADDR_MASK, 8'h00);
    expectReg("R4 toggle clear 2", ADDR_PEND, 8'h00);

    // R6 controller line
    @(negedge clk); ctlIrqIn = 1'b1; #1;
    chk("R6 irq from ctl", irq, 1);
    expectReg("R6 pending bit0", ADDR_PEND, 8'h01);
    hostWrite(ADDR_MASK, 8'h01);
    chk("R6 masked", irq, 0);
    expectReg("R7 ctl still visible", ADDR_PEND, 8'h01);
    hostWrite(ADDR_MASK, 8'h00);
    chk("R6 unmasked", irq, 1);
    @(negedge clk); ctlIrqIn = 1'b0; #1;
    chk("R6 ctl drops", irq, 0);
    expectReg("R6 pending clear", ADDR_PEND, 8'h00);

    // receive path
    hostWrite(ADDR_CTRL, 8'h01);
    rxDma("R2 disabled", 8'h11, 0);
    hostWrite(ADDR_CTRL, 8'h09);
    for (int i = 0; i < 8; i++) rxDma("R2 store", 8'h30 + 8'(i), 1);
    expectReg("R5 no event at 8", ADDR_PEND, 8'h00);
    for (int i = 8; i < 16; i++) rxDma("R2 store", 8'h30 + 8'(i), 1);
    expectReg("R5 rise above half", ADDR_PEND, 8'h02);
    expectReg("R9 status rx full", ADDR_STAT, 8'h0E);
    rxDma("R2 full refused", 8'h77, 0);
    chk("R8 rx irq", irq, 1);
    hostWrite(ADDR_MASK, 8'h02);
    hostWrite(ADDR_MASK, 8'h00);
    expectReg("R5 toggle clear", ADDR_PEND, 8'h00);
    for (int i = 0; i < 16; i++) readRxData("R11 rx order");
    expectReg("R9 status drained", ADDR_STAT, 8'h36);
    for (int i = 0; i < 9; i++) rxDma("R2 store2", 8'hC0 + 8'(i), 1);
    expectReg("R5 half again", ADDR_PEND, 8'h02);
    readRxData("R11 rx order2");
    expectReg("R5 read clears", ADDR_PEND, 8'h00);
    for (int i = 0; i < 8; i++) readRxData("R11 rx order3");

    // R10 collision
    hostWrite(ADDR_CTRL, 8'h05);
    hostWrite(ADDR_DATA, 8'h99);
    @(negedge clk);
    txReq = 1'b1; hostWr = 1'b1; hostAddr = ADDR_DATA; hostWdata = 8'h66;
    #1;
    chk("R10 DMA wins", txAck, 1);
    chk("R10 host stalled", hostReady, 0);
    @(posedge clk); #1;
    txReq = 1'b0;
    @(negedge clk); #1;
    chk("R10 host proceeds", hostReady, 1);
    txQ.push_back(8'h66);
    @(posedge clk); #1;
    hostWr = 1'b0;
    expectReg("R10 one byte landed", ADDR_STAT, 8'h37);
    txDma("R10 R11 stalled byte", 1);
    txDma("R1 empty after", 0);
    chk("R11 tx queue drained", txQ.size(), 0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule